// File: doc/BRIEF.md
# Pulse List Sequencer

This block plays a programmed list of pulse segments out on a single logic output. Each list slot holds an output level, a duration multiplier, an end-of-list flag and a pause flag. While a pattern runs, the block drives the level of the current slot and counts that slot's multiplier in strobes from an external time-base tick. After the count it moves to the next slot. When a slot flagged as end-of-list completes, the block either wraps back to slot 0 (continuous mode) or ends one pass of a burst. In burst mode it stops after the programmed number of passes.

A slot with the pause flag set halts playback at that slot and holds its level until the trigger input pulses again. Playback then continues with the following slot. A start command either begins playback at once or arms the block to wait for a trigger. In retrigger mode, a trigger that arrives while idle restarts the list from slot 0. A stop command ends playback immediately. Two complementary in-progress outputs, a sticky interrupt and a 4-bit status word report activity. The list memory is locked while a pattern is active.

Top module: `pulse_list_seq`

## Requirements
- R1: While running, the output drives the level of the current slot for exactly `mult` ticks, where a multiplier of 0 counts as 1. Segment advance happens only on a clock edge where `tick` is 1, so with `tick` held low the output does not change.
- R2: In continuous mode (`mode_burst`=0), the slot after an end-of-list slot is slot 0. Playback repeats until stopped. A list of 5 high and 5 low with a tick every cycle gives a 10-cycle period at 50 % duty.
- R3: In burst mode (`mode_burst`=1), the list plays `burst_count` times (0 counts as 1). The block then goes idle with the output low. The number of rising edges on `pat_out` equals the number of passes.
- R4: A slot with its pause flag set is entered with its level on `pat_out` and halts there, without timing. Each `trig` pulse moves to the following slot, wrapping after an end-of-list slot. In a list of paused high and paused low slots, the held level alternates on each trigger.
- R5: A `stop` pulse makes the block idle on the next clock: `pat_out` low and not transmitting. Stop has priority over every other command.
- R6: `tip_hi` is 1 and `tip_lo_n` is 0 while a pattern is running or paused at a slot. Otherwise they are 0 and 1. The output is low whenever not transmitting.
- R7: With `irq_en`=1, `irq` is set when a burst completes or when a paused slot is entered. It stays set until `stat_clr` is pulsed.
- R8: `status` bit 0 is transmitting, bit 1 is interrupt, bit 2 is memory busy (block not idle) and bit 3 is write overwrite. After a completed burst with the interrupt enabled, `status` reads 4'h2.
- R9: A list write while the block is not idle is discarded and sets status bit 3. The bit is sticky until `stat_clr`.
- R10: With `trig_en`=1, `start` arms the block. It is busy but not transmitting, with the output low. The next `trig` begins playback from slot 0.
- R11: With `retrig_en`=1, a `trig` while idle starts playback from slot 0 with the burst count reloaded from `burst_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | List slot write strobe |
| wr_addr | input | ADDR_W | Slot index to write |
| wr_mult | input | MULT_W | Duration multiplier in ticks |
| wr_level | input | 1 | Output level of the slot |
| wr_last | input | 1 | End-of-list flag |
| wr_pause | input | 1 | Pause flag |
| start | input | 1 | Start command pulse |
| stop | input | 1 | Stop command pulse |
| mode_burst | input | 1 | 1: burst mode, 0: continuous |
| burst_count | input | BURST_W | Passes per burst |
| trig_en | input | 1 | Start waits for trigger |
| retrig_en | input | 1 | Trigger while idle restarts |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Clears interrupt and overwrite bits |
| tick | input | 1 | Time-base strobe |
| trig | input | 1 | Trigger pulse |
| pat_out | output | 1 | Pattern output |
| tip_hi | output | 1 | In progress, active high |
| tip_lo_n | output | 1 | In progress, active low |
| irq | output | 1 | Completion interrupt |
| status | output | 4 | {overwrite, busy, irq, transmitting} |

## Verification
The bench builds the block with its defaults: 256 slots, 24-bit multipliers and a 16-bit burst count. Only the first two slots are used, so short multipliers of 2, 5 and 10 ticks keep every pass within tens of cycles. The tick is held high for most scenarios, so segment lengths can be counted directly in clock cycles. It is then held low to show that timing freezes. Burst counts of 3, 2 and 0 make the pass boundary, the wrap and the zero-as-one case each visible in a count of rising edges.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_PAUSE = 2'd3
  } pls_state_e;
endpackage

// File: rtl/pls_list_mem.sv
module pls_list_mem #(
  parameter int ADDR_W = 8,
  parameter int MULT_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [MULT_W-1:0] wmult,
  input  logic              wlevel,
  input  logic              wlast,
  input  logic              wpause,
  input  logic [ADDR_W-1:0] raddr,
  output logic [MULT_W-1:0] rmult,
  output logic              rlevel,
  output logic              rlast,
  output logic              rpause
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = MULT_W + 3;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] rword;

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= {wpause, wlast, wlevel, wmult};
    end
  end

  assign rword  = store[raddr];
  assign rmult  = rword[MULT_W-1:0];
  assign rlevel = rword[MULT_W];
  assign rlast  = rword[MULT_W+1];
  assign rpause = rword[MULT_W+2];
endmodule

// File: rtl/pls_seg_timer.sv
module pls_seg_timer #(
  parameter int MULT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MULT_W-1:0] load_val,
  input  logic              run,
  input  logic              tick,
  output logic              seg_done
);
  logic [MULT_W-1:0] cnt_q, cnt_d;
  logic              at_end;

  assign at_end   = (cnt_q <= MULT_W'(1));
  assign seg_done = run && tick && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && tick && !at_end) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pls_ctrl.sv
module pls_ctrl
  import pls_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               trig,
  input  logic               trig_en,
  input  logic               retrig_en,
  input  logic               mode_burst,
  input  logic [BURST_W-1:0] burst_count,
  input  logic               irq_en,
  input  logic               stat_clr,
  input  logic               wr_req,
  input  logic               seg_done,
  input  logic               rd_level,
  input  logic               rd_last,
  input  logic               rd_pause,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               tmr_load,
  output logic               tmr_run,
  output logic               pat_out,
  output logic               xmit,
  output logic               busy,
  output logic               irq,
  output logic               ovf
);
  pls_state_e         st_q, st_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [BURST_W-1:0] rem_q, rem_d;
  logic               last_q, last_d;
  logic               pat_q, pat_d;
  logic               irq_q, irq_d;
  logic               ovf_q, ovf_d;

  logic begin_play, arm, entry_end, finish, load;

  assign begin_play = !stop && (((st_q == ST_IDLE) && start && !trig_en) ||
                                ((st_q == ST_ARMED) && trig) ||
                                ((st_q == ST_IDLE) && retrig_en && trig));
  assign arm        = !stop && (st_q == ST_IDLE) && start && trig_en;
  assign entry_end  = !stop && (((st_q == ST_RUN) && seg_done) ||
                                ((st_q == ST_PAUSE) && trig));
  assign finish     = entry_end && last_q && mode_burst && (rem_q <= BURST_W'(1));
  assign load       = begin_play || (entry_end && !finish);

  assign rd_addr  = (begin_play || last_q) ? '0 : addr_q + 1'b1;
  assign tmr_load = load;
  assign tmr_run  = (st_q == ST_RUN);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    last_d = last_q;
    pat_d  = pat_q;
    irq_d  = irq_q;
    ovf_d  = ovf_q;

    if (stat_clr) begin
      irq_d = 1'b0;
      ovf_d = 1'b0;
    end
    if (wr_req && (st_q != ST_IDLE)) begin
      ovf_d = 1'b1;
    end

    if (stop) begin
      st_d  = ST_IDLE;
      pat_d = 1'b0;
    end else if (arm) begin
      st_d = ST_ARMED;
    end else if (finish) begin
      st_d  = ST_IDLE;
      pat_d = 1'b0;
      if (irq_en) irq_d = 1'b1;
    end else if (load) begin
      addr_d = rd_addr;
      last_d = rd_last;
      pat_d  = rd_level;
      st_d   = rd_pause ? ST_PAUSE : ST_RUN;
      if (rd_pause && irq_en) irq_d = 1'b1;
      if (begin_play) begin
        rem_d = burst_count;
      end else if (last_q && mode_burst) begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      last_q <= 1'b0;
      pat_q  <= 1'b0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      last_q <= last_d;
      pat_q  <= pat_d;
      irq_q  <= irq_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pat_out = pat_q;
  assign xmit    = (st_q == ST_RUN) || (st_q == ST_PAUSE);
  assign busy    = (st_q != ST_IDLE);
  assign irq     = irq_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/pulse_list_seq.sv
module pulse_list_seq #(
  parameter int ADDR_W  = 8,
  parameter int MULT_W  = 24,
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [MULT_W-1:0]  wr_mult,
  input  logic               wr_level,
  input  logic               wr_last,
  input  logic               wr_pause,
  input  logic               start,
  input  logic               stop,
  input  logic               mode_burst,
  input  logic [BURST_W-1:0] burst_count,
  input  logic               trig_en,
  input  logic               retrig_en,
  input  logic               irq_en,
  input  logic               stat_clr,
  input  logic               tick,
  input  logic               trig,
  output logic               pat_out,
  output logic               tip_hi,
  output logic               tip_lo_n,
  output logic               irq,
  output logic [3:0]         status
);
  logic [ADDR_W-1:0] rd_addr;
  logic [MULT_W-1:0] rd_mult;
  logic rd_level, rd_last, rd_pause;
  logic tmr_load, tmr_run, seg_done;
  logic xmit, busy, ovf, wr_ok;

  assign wr_ok = wr_en && !busy;

  pls_list_mem #(.ADDR_W(ADDR_W), .MULT_W(MULT_W)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(wr_addr), .wmult(wr_mult),
    .wlevel(wr_level), .wlast(wr_last), .wpause(wr_pause),
    .raddr(rd_addr), .rmult(rd_mult), .rlevel(rd_level),
    .rlast(rd_last), .rpause(rd_pause)
  );

  pls_seg_timer #(.MULT_W(MULT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(rd_mult),
    .run(tmr_run), .tick(tick), .seg_done(seg_done)
  );

  pls_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .trig(trig),
    .trig_en(trig_en), .retrig_en(retrig_en), .mode_burst(mode_burst),
    .burst_count(burst_count), .irq_en(irq_en), .stat_clr(stat_clr),
    .wr_req(wr_en), .seg_done(seg_done), .rd_level(rd_level),
    .rd_last(rd_last), .rd_pause(rd_pause), .rd_addr(rd_addr),
    .tmr_load(tmr_load), .tmr_run(tmr_run), .pat_out(pat_out),
    .xmit(xmit), .busy(busy), .irq(irq), .ovf(ovf)
  );

  assign tip_hi   = xmit;
  assign tip_lo_n = ~xmit;
  assign status   = {ovf, busy, irq, xmit};
endmodule

// File: rtl/pls_checker.sv
module pls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       start,
  input logic       trig,
  input logic       tick,
  input logic       wr_en,
  input logic       stat_clr,
  input logic       pat_out,
  input logic       tip_hi,
  input logic       tip_lo_n,
  input logic       irq,
  input logic [3:0] status
);
  assert_stop_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!pat_out && !tip_hi && tip_lo_n));

  assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trig && !start && !stop) |=> $stable(pat_out));

  assert_write_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && status[2]) |=> status[3]);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_clr) |=> irq);

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tip_hi |-> !pat_out);

  assert_xmit_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tip_hi |-> status[2]);
endmodule

bind pulse_list_seq pls_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .start(start), .trig(trig),
  .tick(tick), .wr_en(wr_en), .stat_clr(stat_clr), .pat_out(pat_out),
  .tip_hi(tip_hi), .tip_lo_n(tip_lo_n), .irq(irq), .status(status)
);

// File: tb/tb_pulse_list_seq.sv
`timescale 1ns/1ps
module tb_pulse_list_seq;
  logic clk, rst_n;
  logic wr_en, wr_level, wr_last, wr_pause;
  logic [7:0] wr_addr;
  logic [23:0] wr_mult;
  logic start, stop, mode_burst, trig_en, retrig_en, irq_en, stat_clr, tick, trig;
  logic [15:0] burst_count;
  logic pat_out, tip_hi, tip_lo_n, irq;
  logic [3:0] status;
  int checks = 0;
  int fails = 0;

  pulse_list_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_mult(wr_mult), .wr_level(wr_level), .wr_last(wr_last),
    .wr_pause(wr_pause), .start(start), .stop(stop),
    .mode_burst(mode_burst), .burst_count(burst_count), .trig_en(trig_en),
    .retrig_en(retrig_en), .irq_en(irq_en), .stat_clr(stat_clr),
    .tick(tick), .trig(trig), .pat_out(pat_out), .tip_hi(tip_hi),
    .tip_lo_n(tip_lo_n), .irq(irq), .status(status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic write_slot(input int a, input int m, input logic lv,
                            input logic ls, input logic pz);
    wr_addr = 8'(a); wr_mult = 24'(m); wr_level = lv; wr_last = ls; wr_pause = pz;
    pulse(wr_en);
  endtask

  task automatic count_rises(input int n, output int r);
    logic prev;
    prev = pat_out;
    r = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pat_out && !prev) r++;
      prev = pat_out;
    end
  endtask

  task automatic t_reset;
    check("R6 reset tip_hi", tip_hi, 0);
    check("R6 reset tip_lo_n", tip_lo_n, 1);
    check("R8 reset status", status, 0);
    check("R5 reset pat_out", pat_out, 0);
  endtask

  task automatic t_square;
    int hi, run;
    write_slot(0, 5, 1'b1, 1'b0, 1'b0);
    write_slot(1, 5, 1'b0, 1'b1, 1'b0);
    mode_burst = 1'b0;
    pulse(start);
    check("R1 first slot level", pat_out, 1);
    check("R6 tip_hi running", tip_hi, 1);
    check("R6 tip_lo_n running", tip_lo_n, 0);
    run = 0;
    while (pat_out) begin run++; @(negedge clk); end
    check("R1 high segment length", run, 5);
    run = 0;
    while (!pat_out) begin run++; @(negedge clk); end
    check("R1 low segment length", run, 5);
    hi = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (pat_out) hi++; end
    check("R2 continuous duty over 100 cycles", hi, 50);
    tick = 1'b0;
    run = pat_out;
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pat_out != run[0]) hi++; end
    check("R1 no change without tick", hi, 0);
    tick = 1'b1;
    pulse(stop);
    check("R5 stop output low", pat_out, 0);
    check("R5 stop tip_hi", tip_hi, 0);
    check("R6 stop tip_lo_n", tip_lo_n, 1);
  endtask

  task automatic t_overwrite;
    pulse(start);
    write_slot(0, 5, 1'b0, 1'b0, 1'b0);
    check("R9 overwrite bit", status[3], 1);
    pulse(stop);
    pulse(start);
    check("R9 slot 0 unchanged", pat_out, 1);
    pulse(stop);
    pulse(stat_clr);
    check("R9 overwrite cleared", status[3], 0);
  endtask

  task automatic t_burst;
    int r;
    write_slot(0, 2, 1'b1, 1'b0, 1'b0);
    write_slot(1, 2, 1'b0, 1'b1, 1'b0);
    mode_burst = 1'b1; irq_en = 1'b1; burst_count = 16'd3;
    pulse(start);
    check("R6 tip during burst", tip_hi, 1);
    check("R7 no irq mid burst", irq, 0);
    count_rises(60, r);
    check("R3 burst of 3 pulses", r + 1, 3);
    check("R8 status after burst", status, 2);
    check("R7 irq after burst", irq, 1);
    pulse(stat_clr);
    burst_count = 16'd0;
    pulse(start);
    count_rises(60, r);
    check("R3 count 0 gives one pulse", r + 1, 1);
    check("R3 idle after burst", tip_hi, 0);
  endtask

  task automatic t_retrig;
    int r;
    pulse(stat_clr);
    retrig_en = 1'b1; burst_count = 16'd2;
    pulse(trig);
    check("R11 retrigger starts high", pat_out, 1);
    count_rises(60, r);
    check("R11 burst reloaded to 2", r + 1, 2);
    retrig_en = 1'b0;
  endtask

  task automatic t_arm;
    trig_en = 1'b1; mode_burst = 1'b0;
    pulse(start);
    repeat (5) @(negedge clk);
    check("R10 armed not transmitting", tip_hi, 0);
    check("R10 armed output low", pat_out, 0);
    check("R10 armed busy", status[2], 1);
    pulse(trig);
    check("R10 trigger begins", tip_hi, 1);
    check("R10 trigger slot 0 level", pat_out, 1);
    pulse(stop);
    trig_en = 1'b0;
  endtask

  task automatic t_pause;
    write_slot(0, 10, 1'b1, 1'b0, 1'b1);
    write_slot(1, 10, 1'b0, 1'b1, 1'b1);
    mode_burst = 1'b0; irq_en = 1'b1;
    pulse(stat_clr);
    pulse(start);
    check("R4 paused high", pat_out, 1);
    check("R7 irq at pause", irq, 1);
    repeat (30) @(negedge clk);
    check("R4 held high", pat_out, 1);
    check("R6 paused transmitting", tip_hi, 1);
    pulse(stat_clr);
    pulse(trig);
    check("R4 next slot low", pat_out, 0);
    check("R7 irq at second pause", irq, 1);
    repeat (15) @(negedge clk);
    check("R4 held low", pat_out, 0);
    pulse(trig);
    check("R4 wrap back high", pat_out, 1);
    pulse(stop);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_addr = 0; wr_mult = 0; wr_level = 0; wr_last = 0; wr_pause = 0;
    start = 0; stop = 0; mode_burst = 0; burst_count = 0; trig_en = 0;
    retrig_en = 0; irq_en = 0; stat_clr = 0; tick = 1; trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_square;
    t_overwrite;
    t_burst;
    t_retrig;
    t_arm;
    t_pause;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule